// File: doc/BRIEF.md
# Reference Lock State Machine

This block follows a digital PLL through its operating states: free-run, pre-locked, locked, holdover and a second pre-lock state, pre-locked2. A pre-locked2 episode begins when a reference is picked up again after holdover, or when a higher-priority reference comes back while revertive switching is on. The current state is held in a 3-bit status register that software or neighbouring logic can read directly from `state_code`.

Alarm detection and source priority live elsewhere. The block only sees a reference-selected flag, the activity and frequency alarm flags of that reference, a phase-lock indication, a revertive enable, a one-cycle "higher-priority source back" pulse and a once-per-second tick. Each pre-lock state runs a deadline counted in ticks. If the deadline passes without lock, the machine falls back and sends the source selector a one-cycle request to choose a different reference.

The deadline length, `LOCK_LIMIT`, is counted in ticks and defaults to 100. Because the tick comes in on a pin, a short tick spacing can be used in simulation.

Top module: `lock_state_tracker`

## Requirements
- R1: After reset, `state_code` is free-run (3'b001) and `reselect_req` is 0.
- R2: `state_code` only ever carries free-run=3'b001, holdover=3'b010, locked=3'b100, pre-locked=3'b101 or pre-locked2=3'b110. Every transition shows on `state_code` one clock after the inputs that cause it.
- R3: A reference counts as faulty when `ref_selected` is 0 or either alarm flag is 1. In free-run, a selected and clean reference moves the machine to pre-locked. Either alarm alone keeps it in free-run.
- R4: In pre-locked, `phase_locked` moves the machine to locked. A faulty reference returns it to free-run.
- R5: In locked, a faulty reference (activity alarm, frequency alarm, or deselection) moves the machine to holdover.
- R6: In holdover, a selected and clean reference moves the machine to pre-locked2.
- R7: In locked with a clean reference, `hp_restored` moves the machine to pre-locked2 when `revertive_en` is 1. When `revertive_en` is 0 the pulse is ignored and the state stays locked.
- R8: In pre-locked2, `phase_locked` moves the machine to locked. A faulty reference moves it to holdover without a reselect request.
- R9: In a pre-lock state, suppose the `LOCK_LIMIT`-th `sec_tick` seen since the state was entered arrives without lock. Then pre-locked2 goes to holdover and pre-locked goes to free-run. `reselect_req` is 1 for exactly that one cycle, alongside the new state.
- R10: Within a pre-lock state the causes rank as follows: a faulty reference first, then `phase_locked`, then the deadline.
- R11: Ticks have no effect outside the pre-lock states. The tick count restarts from zero on every entry into a pre-lock state, including a pre-locked2 entry through revertive switching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_selected | input | 1 | A reference is chosen and applied to the loop |
| act_alarm | input | 1 | Activity alarm on the chosen reference |
| freq_alarm | input | 1 | Frequency alarm on the chosen reference |
| phase_locked | input | 1 | Phase lock detected |
| revertive_en | input | 1 | Revertive switching enabled |
| hp_restored | input | 1 | One-cycle pulse: a higher-priority source is back |
| sec_tick | input | 1 | One-cycle pulse per second |
| state_code | output | 3 | Current operating state (status register) |
| reselect_req | output | 1 | One-cycle request for a new source choice |

## Verification
Each state transition is registered, so a wrong next-state decision shows on `state_code` one clock after the inputs that caused it. The bench compares `state_code` every cycle and therefore catches such a fault at once. A deadline counter that counts wrongly or fails to restart only shows up when the `LOCK_LIMIT`-th tick arrives: the fallback to holdover or free-run comes early or late, and the `reselect_req` pulse is misplaced. Directed runs therefore count ticks exactly up to the limit, both after a normal entry and after a revertive one.

// File: rtl/lock_tracker_pkg.sv
package lock_tracker_pkg;
  typedef enum logic [2:0] {
    ST_FREE = 3'b001,
    ST_HOLD = 3'b010,
    ST_LOCK = 3'b100,
    ST_PRE  = 3'b101,
    ST_PRE2 = 3'b110
  } lock_state_e;
endpackage

// File: rtl/lt_ref_qual.sv
module lt_ref_qual (
  input  logic ref_selected,
  input  logic act_alarm,
  input  logic freq_alarm,
  output logic ref_faulty
);
  // Reference is unusable when not applied or when any alarm is raised.
  assign ref_faulty = !ref_selected || act_alarm || freq_alarm;
endmodule

// File: rtl/lt_deadline.sv
module lt_deadline #(
  parameter int LOCK_LIMIT = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,    // machine sits in a pre-lock state
  input  logic restart,  // state changes this cycle
  input  logic tick,
  output logic expired
);
  localparam int CW = $clog2(LOCK_LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LOCK_LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || restart || !armed) cnt_q <= '0;
    else if (tick)                   cnt_q <= cnt_q + 1'b1;
  end

  assign expired = armed && tick && (cnt_q == LAST);
endmodule

// File: rtl/lt_fsm.sv
module lt_fsm
  import lock_tracker_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ref_faulty,
  input  logic        phase_locked,
  input  logic        revertive_en,
  input  logic        hp_restored,
  input  logic        expired,
  output lock_state_e state_q,
  output logic        armed,
  output logic        changing,
  output logic        reselect_q
);
  lock_state_e state_d;
  logic        timeout_take;

  always_comb begin
    state_d      = state_q;
    timeout_take = 1'b0;
    unique case (state_q)
      ST_FREE: if (!ref_faulty) state_d = ST_PRE;
      ST_PRE: begin
        if (ref_faulty)        state_d = ST_FREE;
        else if (phase_locked) state_d = ST_LOCK;
        else if (expired) begin
          state_d      = ST_FREE;
          timeout_take = 1'b1;
        end
      end
      ST_LOCK: begin
        if (ref_faulty)                       state_d = ST_HOLD;
        else if (revertive_en && hp_restored) state_d = ST_PRE2;
      end
      ST_HOLD: if (!ref_faulty) state_d = ST_PRE2;
      ST_PRE2: begin
        if (ref_faulty)        state_d = ST_HOLD;
        else if (phase_locked) state_d = ST_LOCK;
        else if (expired) begin
          state_d      = ST_HOLD;
          timeout_take = 1'b1;
        end
      end
      default: state_d = ST_FREE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_FREE;
      reselect_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      reselect_q <= timeout_take;
    end
  end

  assign armed    = (state_q == ST_PRE) || (state_q == ST_PRE2);
  assign changing = (state_d != state_q);
endmodule

// File: rtl/lock_state_tracker.sv
module lock_state_tracker
  import lock_tracker_pkg::*;
#(
  parameter int LOCK_LIMIT = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_selected,
  input  logic       act_alarm,
  input  logic       freq_alarm,
  input  logic       phase_locked,
  input  logic       revertive_en,
  input  logic       hp_restored,
  input  logic       sec_tick,
  output logic [2:0] state_code,
  output logic       reselect_req
);
  logic        ref_faulty, armed, changing, expired;
  lock_state_e state_q;

  lt_ref_qual u_qual (
    .ref_selected(ref_selected),
    .act_alarm   (act_alarm),
    .freq_alarm  (freq_alarm),
    .ref_faulty  (ref_faulty)
  );

  lt_deadline #(.LOCK_LIMIT(LOCK_LIMIT)) u_deadline (
    .clk    (clk),
    .rst_n  (rst_n),
    .armed  (armed),
    .restart(changing),
    .tick   (sec_tick),
    .expired(expired)
  );

  lt_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .ref_faulty  (ref_faulty),
    .phase_locked(phase_locked),
    .revertive_en(revertive_en),
    .hp_restored (hp_restored),
    .expired     (expired),
    .state_q     (state_q),
    .armed       (armed),
    .changing    (changing),
    .reselect_q  (reselect_req)
  );

  assign state_code = state_q;
endmodule

// File: rtl/lock_tracker_chk.sv
module lock_tracker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ref_selected,
  input logic       act_alarm,
  input logic       freq_alarm,
  input logic       revertive_en,
  input logic       hp_restored,
  input logic [2:0] state_code,
  input logic       reselect_req
);
  logic bad_ref;
  assign bad_ref = !ref_selected || act_alarm || freq_alarm;

  // R2
  legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_code inside {3'b001, 3'b010, 3'b100, 3'b101, 3'b110});

  // R9
  reselect_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reselect_req |=> !reselect_req);

  // R9
  reselect_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reselect_req |-> ((state_code == 3'b010 && $past(state_code) == 3'b110) ||
                      (state_code == 3'b001 && $past(state_code) == 3'b101)));

  // R5
  lock_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'b100 && bad_ref) |=> state_code == 3'b010);

  // R6
  hold_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'b010 && !bad_ref) |=> state_code == 3'b110);

  // R7
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'b100 && !bad_ref && !(revertive_en && hp_restored))
      |=> state_code == 3'b100);
endmodule

bind lock_state_tracker lock_tracker_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ref_selected(ref_selected),
  .act_alarm   (act_alarm),
  .freq_alarm  (freq_alarm),
  .revertive_en(revertive_en),
  .hp_restored (hp_restored),
  .state_code  (state_code),
  .reselect_req(reselect_req)
);

// File: tb/tb_lock_state_tracker.sv
module tb_lock_state_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT = 5;
  localparam logic [2:0] S_FREE = 3'b001, S_HOLD = 3'b010, S_LOCK = 3'b100,
                         S_PRE = 3'b101, S_PRE2 = 3'b110;

  logic clk = 0, rst_n = 0;
  logic rs = 0, aa = 0, fa = 0, pl = 0, rev = 0, hp = 0, tk = 0;
  logic [2:0] state_code;
  logic reselect_req;

  int checks = 0, errors = 0;
  logic [2:0] m_state = S_FREE;
  logic m_rsel = 0;
  int m_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lock_state_tracker #(.LOCK_LIMIT(LIMIT)) dut (
    .clk(clk), .rst_n(rst_n), .ref_selected(rs), .act_alarm(aa),
    .freq_alarm(fa), .phase_locked(pl), .revertive_en(rev),
    .hp_restored(hp), .sec_tick(tk), .state_code(state_code),
    .reselect_req(reselect_req));

  function automatic logic [2:0] next_state(input logic [2:0] s, input int cnt,
                                            output logic rsel);
    logic lost, expd;
    lost = !rs || aa || fa;
    expd = (s == S_PRE || s == S_PRE2) && tk && (cnt == LIMIT - 1);
    rsel = 0;
    next_state = s;
    case (s)
      S_FREE: if (!lost) next_state = S_PRE;
      S_PRE:  if (lost) next_state = S_FREE;
              else if (pl) next_state = S_LOCK;
              else if (expd) begin next_state = S_FREE; rsel = 1; end
      S_LOCK: if (lost) next_state = S_HOLD;
              else if (rev && hp) next_state = S_PRE2;
      S_HOLD: if (!lost) next_state = S_PRE2;
      S_PRE2: if (lost) next_state = S_HOLD;
              else if (pl) next_state = S_LOCK;
              else if (expd) begin next_state = S_HOLD; rsel = 1; end
      default: next_state = S_FREE;
    endcase
  endfunction

  task automatic check(input string tag, input logic [2:0] exp_s, input logic exp_r);
    checks++;
    if (state_code !== exp_s) begin
      errors++;
      $display("FAIL %s state_code actual=%b expected=%b", tag, state_code, exp_s);
    end
    checks++;
    if (reselect_req !== exp_r) begin
      errors++;
      $display("FAIL %s reselect_req actual=%b expected=%b", tag, reselect_req, exp_r);
    end
  endtask

  // Inputs already set after a negedge; advance one clock and compare.
  task automatic step(input string tag);
    logic [2:0] ns;
    logic r;
    ns = next_state(m_state, m_cnt, r);
    if (ns != m_state || !(m_state == S_PRE || m_state == S_PRE2)) m_cnt = 0;
    else if (tk) m_cnt++;
    m_state = ns;
    m_rsel = r;
    @(posedge clk);
    @(negedge clk);
    check(tag, m_state, m_rsel);
  endtask

  task automatic drive(input logic r_, a_, f_, p_, v_, h_, t_);
    rs = r_; aa = a_; fa = f_; pl = p_; rev = v_; hp = h_; tk = t_;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    check("R1 reset", S_FREE, 1'b0);
    rst_n = 1;

    // R3: alarms keep free-run
    drive(1,1,0,0,0,0,0); step("R3 act alarm blocks");
    drive(1,0,1,0,0,0,0); step("R3 freq alarm blocks");
    drive(1,0,0,0,0,0,1); step("R3 to pre-locked");
    // R4: fault back to free-run, then lock
    drive(0,0,0,0,0,0,0); step("R4 fault to free-run");
    drive(1,0,0,0,0,0,0); step("R3 re-enter pre-locked");
    drive(1,0,0,1,0,0,0); step("R4 lock");
    // R11: ticks in locked ignored
    for (int i = 0; i < 8; i++) begin drive(1,0,0,0,0,0,1); step("R11 ticks in locked"); end
    // R7: revertive off ignores restore
    drive(1,0,0,0,0,1,0); step("R7 revertive off");
    drive(1,0,0,0,1,1,0); step("R7 revertive to pre-locked2");
    // R11/R9: fresh count after revertive entry
    for (int i = 0; i < LIMIT - 1; i++) begin drive(1,0,0,0,0,0,1); step("R11 count before limit"); end
    drive(1,0,0,0,0,0,0); step("R11 no tick holds");
    drive(1,0,0,0,0,0,1); step("R9 timeout to holdover");
    drive(1,0,0,0,0,0,0); step("R9 pulse ends, R6 holdover to pre-locked2");
    // R10: fault beats lock
    drive(1,1,0,1,0,0,0); step("R10 fault over lock");
    drive(1,0,0,0,0,0,0); step("R6 holdover exit");
    for (int i = 0; i < LIMIT - 1; i++) begin drive(1,0,0,0,0,0,1); step("R9 counting"); end
    drive(1,0,0,1,0,0,1); step("R10 lock over deadline");
    // R5: deselection in locked
    drive(0,0,0,0,0,0,0); step("R5 deselect to holdover");
    drive(1,0,0,0,0,0,0); step("R6 to pre-locked2");
    drive(1,0,1,0,0,0,0); step("R8 fault to holdover no reselect");
    drive(1,0,0,0,0,0,0); step("R6 again");
    drive(1,0,0,1,0,0,0); step("R8 lock from pre-locked2");
    drive(1,1,0,0,0,0,0); step("R5 activity alarm to holdover");
    // R9 from pre-locked: reset to free-run
    rst_n = 0; drive(0,0,0,0,0,0,0);
    @(posedge clk); @(negedge clk);
    m_state = S_FREE; m_cnt = 0; m_rsel = 0;
    check("R1 second reset", S_FREE, 1'b0);
    rst_n = 1;
    drive(1,0,0,0,0,0,0); step("R3 to pre-locked");
    for (int i = 0; i < LIMIT; i++) begin drive(1,0,0,0,0,0,1); step("R9 pre-locked deadline"); end

    // Random mix checked against the model (R2, R10)
    for (int i = 0; i < 4000; i++) begin
      drive(($urandom % 8) != 0, ($urandom % 16) == 0, ($urandom % 16) == 0,
            ($urandom % 10) == 0, ($urandom % 2) == 0, ($urandom % 12) == 0,
            ($urandom % 3) == 0);
      step("R2 random");
    end
    finish_run();
  end
endmodule